// File: doc/BRIEF.md
# Bidirectional Port Controller with Open-Drain Option

This block controls a port of eight bidirectional pins through a small byte-wide register bus. Software programs three read/write registers: a function-select register, a driver-type register and an output-value register. It can also read a fourth register that shows the level on the pins. For each pin, the block decides two things:

- which source drives the pin: the output-value register or an on-chip peripheral signal;
- which driver the pin uses: a complementary driver, or an open-drain driver that can also serve as an input.

The block turns that decision into per-pin pull-up and pull-down enables for the pad cell. The level at the pad comes back through a two-flop synchronizer and is readable at a fixed latency.

When a pin is handed to a peripheral, the output-value register still accepts writes and keeps them, but the pin does not change. Software can therefore preload a pin value and switch the pin back to port control without a glitch. After reset every pin is an open-drain input with its driver released, so an external pull-up can hold the pin high.

Top module: `bport_gpio`

## Requirements
- R1: After reset, function-select reads 0x00, driver-type reads 0xFF and output-value reads 0xFF. Every pad has pull-up and pull-down enables low.
- R2: A write at offset 0 (function-select), offset 2 (driver-type) or offset 4 (output-value) is read back unchanged at the same offset.
- R3: A pin with driver-type bit 0 is complementary. Exactly one of its pull-up and pull-down enables is high, and pull-up is high when the selected value is 1.
- R4: A pin with driver-type bit 1 is open-drain. Its pull-up enable is always low, and its pull-down enable is high exactly when the selected value is 0.
- R5: A pin with function-select bit 0 takes its selected value from the output-value bit. A write to offset 4 reaches the pad enables in the cycle right after the write edge.
- R6: A pin with function-select bit 1 takes its selected value from the peripheral input. Writes to output-value are still stored but leave that pad unchanged, and the stored bit drives the pad once the function-select bit returns to 0.
- R7: Offset 6 returns the pad level sampled two clock edges earlier, whatever the function-select and driver-type settings are.
- R8: Writes to offset 6 change no register.
- R9: Odd offsets (1, 3, 5, 7) read 0x00, and writes to them change no register.
- R10: The read data is 0x00 in any cycle in which the read strobe is low. When the strobe is high, the read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| periph_out | input | 8 | Per-pin value from on-chip peripherals |
| pad_in | input | 8 | Level sensed at each pad |
| pad_pu_en | output | 8 | Per-pin pull-up enable |
| pad_pd_en | output | 8 | Per-pin pull-down enable |

## Verification
A corrupted configuration bit shows at the pad enables in the very next cycle, because the drive logic after the registers has no storage. The bench compares both enable vectors against its model on every clock, so such a fault is caught at once even when no read is in progress. A fault in the synchronizer depth shows as the pin status arriving one cycle early or late. The bench holds the read strobe on offset 6 while it changes the pad input, so this fault appears within two cycles of the first pad change. A write that lands in the wrong register shows up on the next readback. If the wrong register is one that shapes the drive, the fault also shows at the pads in the following cycle.

// File: rtl/bport_pkg.sv
package bport_pkg;

    localparam int BP_ADDR_W = 3;
    localparam int BP_PORT_W = 8;

    // Offsets that software decodes
    localparam logic [BP_ADDR_W-1:0] OFS_FUNC = 3'd0;
    localparam logic [BP_ADDR_W-1:0] OFS_DRV  = 3'd2;
    localparam logic [BP_ADDR_W-1:0] OFS_OUT  = 3'd4;
    localparam logic [BP_ADDR_W-1:0] OFS_STAT = 3'd6;

    typedef enum logic [2:0] {
        SEL_FUNC,
        SEL_DRV,
        SEL_OUT,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic pull_up;
        logic pull_dn;
    } pad_drive_t;

    function automatic reg_sel_e decode_ofs(input logic [BP_ADDR_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_FUNC: s = SEL_FUNC;
            OFS_DRV:  s = SEL_DRV;
            OFS_OUT:  s = SEL_OUT;
            OFS_STAT: s = SEL_STAT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Open-drain never pulls up; complementary drives both ways
    function automatic pad_drive_t drive_of(input logic value, input logic open_drain);
        pad_drive_t d;
        d.pull_dn = ~value;
        d.pull_up = value & ~open_drain;
        return d;
    endfunction

endpackage

// File: rtl/bport_regfile.sv
module bport_regfile
    import bport_pkg::*;
#(
    parameter int WIDTH = BP_PORT_W,
    parameter logic [WIDTH-1:0] FUNC_RST = '0,
    parameter logic [WIDTH-1:0] DRV_RST  = '1,
    parameter logic [WIDTH-1:0] OUT_RST  = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [BP_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     func_q,
    output logic [WIDTH-1:0]     drv_q,
    output logic [WIDTH-1:0]     out_q
);

    reg_sel_e wsel;

    always_comb begin
        wsel = decode_ofs(addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= FUNC_RST;
            drv_q  <= DRV_RST;
            out_q  <= OUT_RST;
        end else if (wr) begin
            case (wsel)
                SEL_FUNC: func_q <= wdata;
                SEL_DRV:  drv_q  <= wdata;
                SEL_OUT:  out_q  <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/bport_sync.sv
module bport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/bport_pin_drv.sv
module bport_pin_drv
    import bport_pkg::*;
(
    input  logic use_periph,
    input  logic open_drain,
    input  logic port_val,
    input  logic periph_val,
    output logic pull_up,
    output logic pull_dn
);

    logic       chosen;
    pad_drive_t drv;

    always_comb begin
        chosen  = use_periph ? periph_val : port_val;
        drv     = drive_of(chosen, open_drain);
        pull_up = drv.pull_up;
        pull_dn = drv.pull_dn;
    end

endmodule

// File: rtl/bport_rdmux.sv
module bport_rdmux
    import bport_pkg::*;
#(
    parameter int WIDTH = BP_PORT_W
) (
    input  logic                 rd,
    input  logic [BP_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]     func_q,
    input  logic [WIDTH-1:0]     drv_q,
    input  logic [WIDTH-1:0]     out_q,
    input  logic [WIDTH-1:0]     stat,
    output logic [WIDTH-1:0]     rdata
);

    reg_sel_e rsel;

    always_comb begin
        rsel  = decode_ofs(addr);
        rdata = '0;
        if (rd) begin
            case (rsel)
                SEL_FUNC: rdata = func_q;
                SEL_DRV:  rdata = drv_q;
                SEL_OUT:  rdata = out_q;
                SEL_STAT: rdata = stat;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/bport_gpio.sv
module bport_gpio
    import bport_pkg::*;
#(
    parameter int WIDTH       = BP_PORT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BP_ADDR_W-1:0] bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    input  logic [WIDTH-1:0]     periph_out,
    input  logic [WIDTH-1:0]     pad_in,
    output logic [WIDTH-1:0]     pad_pu_en,
    output logic [WIDTH-1:0]     pad_pd_en
);

    logic [WIDTH-1:0] mode_r;
    logic [WIDTH-1:0] dir_r;
    logic [WIDTH-1:0] data_r;
    logic [WIDTH-1:0] pin_stat;

    bport_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .func_q (mode_r),
        .drv_q  (dir_r),
        .out_q  (data_r)
    );

    bport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pin_stat)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        bport_pin_drv u_drv (
            .use_periph (mode_r[i]),
            .open_drain (dir_r[i]),
            .port_val   (data_r[i]),
            .periph_val (periph_out[i]),
            .pull_up    (pad_pu_en[i]),
            .pull_dn    (pad_pd_en[i])
        );
    end

    bport_rdmux #(.WIDTH(WIDTH)) u_rd (
        .rd     (bus_rd),
        .addr   (bus_addr),
        .func_q (mode_r),
        .drv_q  (dir_r),
        .out_q  (data_r),
        .stat   (pin_stat),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/bport_gpio_chk.sv
module bport_gpio_chk
    import bport_pkg::*;
#(
    parameter int WIDTH = BP_PORT_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic [BP_ADDR_W-1:0] bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [WIDTH-1:0]     bus_wdata,
    input logic [WIDTH-1:0]     bus_rdata,
    input logic [WIDTH-1:0]     pad_in,
    input logic [WIDTH-1:0]     pad_pu_en,
    input logic [WIDTH-1:0]     pad_pd_en,
    input logic [WIDTH-1:0]     mode_r,
    input logic [WIDTH-1:0]     dir_r,
    input logic [WIDTH-1:0]     data_r,
    input logic [WIDTH-1:0]     pin_stat
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_reset_release_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_pu_en == '0 && pad_pd_en == '0));

    p_push_pull_r3: assert property (@(posedge clk) disable iff (rst)
        (((pad_pu_en ^ pad_pd_en) | dir_r) == '1));

    p_no_contention_r3: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu_en & pad_pd_en) == '0));

    p_od_no_pullup_r4: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu_en & dir_r) == '0));

    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_OUT) |=> (data_r == $past(bus_wdata)));

    p_status_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (pin_stat == $past(pad_in, 2)));

    p_status_ro_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_STAT) |=>
            ($stable(mode_r) && $stable(dir_r) && $stable(data_r)));

    p_odd_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[0]) |=>
            ($stable(mode_r) && $stable(dir_r) && $stable(data_r)));

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

endmodule

bind bport_gpio bport_gpio_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_pu_en (pad_pu_en),
    .pad_pd_en (pad_pd_en),
    .mode_r    (mode_r),
    .dir_r     (dir_r),
    .data_r    (data_r),
    .pin_stat  (pin_stat)
);

// File: tb/sim_bport_gpio.sv
`timescale 1ns/1ps
module sim_bport_gpio;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] periph_out = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_pu_en;
    logic [7:0] pad_pd_en;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    bport_gpio u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_out(periph_out), .pad_in(pad_in),
        .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en)
    );

    // Behavioural reference model
    logic [7:0] m_sel, m_type, m_val;
    logic [7:0] seen[$];

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 8'h00; m_type = 8'hFF; m_val = 8'hFF;
            seen.delete();
        end else begin
            if (bus_wr) begin
                if (bus_addr == 3'd0) m_sel = bus_wdata;
                else if (bus_addr == 3'd2) m_type = bus_wdata;
                else if (bus_addr == 3'd4) m_val = bus_wdata;
            end
            seen.push_back(pad_in);
            if (seen.size() > 2) void'(seen.pop_front());
        end
    end

    function automatic logic [7:0] exp_stat();
        return (seen.size() == 2) ? seen[0] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!bus_rd) return 8'h00;
        case (bus_addr)
            3'd0: return m_sel;
            3'd2: return m_type;
            3'd4: return m_val;
            3'd6: return exp_stat();
            default: return 8'h00;
        endcase
    endfunction

    task automatic exp_pads(output logic [7:0] pu, output logic [7:0] pd);
        for (int i = 0; i < 8; i++) begin
            logic v;
            v = m_sel[i] ? periph_out[i] : m_val[i];
            if (m_type[i]) begin pu[i] = 1'b0; pd[i] = !v; end
            else           begin pu[i] = v;    pd[i] = !v; end
        end
    endtask

    task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%02h expected=%02h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] epu, epd;
            exp_pads(epu, epd);
            check(cur_req, "pull-up", pad_pu_en, epu);
            check(cur_req, "pull-down", pad_pd_en, epd);
            check(bus_rd ? cur_req : "R10", "rdata", bus_rdata, exp_rdata());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        step();
        check("R1", "pu after reset", pad_pu_en, 8'h00);
        check("R1", "pd after reset", pad_pd_en, 8'h00);
        rd(3'd0); rd(3'd2); rd(3'd4);
        // R2, R3, R5: complementary drive from port register
        cur_req = "R2";
        wr(3'd2, 8'h00); wr(3'd4, 8'hA5);
        rd(3'd2); rd(3'd4);
        cur_req = "R3";
        step();
        check("R3", "pu push-pull", pad_pu_en, 8'hA5);
        check("R3", "pd push-pull", pad_pd_en, 8'h5A);
        cur_req = "R5";
        wr(3'd4, 8'h0F);
        check("R5", "pu next cycle", pad_pu_en, 8'h0F);
        wr(3'd4, 8'hF0);
        // R4: open-drain
        cur_req = "R4";
        wr(3'd2, 8'hFF); wr(3'd4, 8'h3C);
        check("R4", "od pu", pad_pu_en, 8'h00);
        check("R4", "od pd", pad_pd_en, 8'hC3);
        wr(3'd2, 8'h0F); wr(3'd4, 8'h96);
        rd(3'd2);
        // R6: peripheral control
        cur_req = "R6";
        periph_out = 8'h5A;
        wr(3'd2, 8'h00); wr(3'd0, 8'hF0);
        rd(3'd0);
        wr(3'd4, 8'h00);
        check("R6", "periph pu", pad_pu_en, 8'h50);
        rd(3'd4);
        periph_out = 8'hA0;
        step();
        check("R6", "periph follow", pad_pu_en, 8'hA0);
        wr(3'd0, 8'h00);
        check("R6", "stored value applies", pad_pu_en, 8'h00);
        wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
        for (int k = 0; k < 8; k++) begin periph_out = 8'(k * 37); step(); end
        wr(3'd0, 8'h00);
        // R7: pin status latency under several settings
        cur_req = "R7";
        bus_addr = 3'd6; bus_rd = 1'b1;
        for (int k = 0; k < 12; k++) begin
            pad_in = 8'(k * 29 + 3);
            if (k == 4) begin bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h00; end
            if (k == 5) begin bus_wr = 1'b0; bus_addr = 3'd6; end
            step();
        end
        pad_in = 8'hC6; step(); step();
        check("R7", "status after 2", bus_rdata, 8'hC6);
        bus_rd = 1'b0;
        // R8: status register read-only
        cur_req = "R8";
        wr(3'd6, 8'h55);
        rd(3'd0); rd(3'd2); rd(3'd4); rd(3'd6);
        // R9: odd offsets
        cur_req = "R9";
        wr(3'd1, 8'h11); wr(3'd3, 8'h33); wr(3'd5, 8'h55); wr(3'd7, 8'h77);
        rd(3'd1); rd(3'd3); rd(3'd5); rd(3'd7);
        rd(3'd0); rd(3'd2); rd(3'd4);
        // R10: idle read data
        cur_req = "R10";
        bus_addr = 3'd4; step();
        check("R10", "idle rdata", bus_rdata, 8'h00);
        // Reset again mid-run: R1
        cur_req = "R1";
        rst = 1'b1; step(); rst = 1'b0; step();
        rd(3'd0); rd(3'd2); rd(3'd4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule